// File: doc/BRIEF.md
# Multi-Channel PWM Timer

The block is a pulse-width modulation timer in which one 16-bit counter drives eight compare channels. Software places it on a simple 32-bit register bus. The bus sets a clock source, a power-of-two prescale factor, a start count and a wrap value, and each channel gets a compare value and a control word. One control bit chooses the counting scheme. In the first scheme the counter rises and reloads, which gives edge-aligned pulses. In the second it rises and then falls, which gives pulses centred in the period.

Each channel can run as a high-true or a low-true PWM output. A per-channel mask forces a pin to its inactive level. Pins whose channel is stopped or not configured show a software-chosen initial level. All pins are registered, so each pin follows the counter state with one clock of latency.

Top module: `mc_pwm_timer`

## Requirements
- R1: After reset every register reads as zero, the counter is 0 and all eight pins are low.
- R2: Registers sit at byte offsets: timer control 0x00, counter 0x04, wrap value 0x08, start count 0x4C, initial levels 0x5C, mask 0x60. Channel n has its control word at 0x0C+8n and its compare value at 0x10+8n. Written values read back, reduced to their implemented bits: 6 bits of timer control, 16 of each value, bits 5/3/2 of channel control, and 8 bits of levels and mask.
- R3: Timer control bits [4:3] pick the count source. 00 halts the counter. 01 counts on every clock. 10 counts on `fix_tick` pulses. 11 counts on `ext_tick` pulses.
- R4: Timer control bits [2:0] hold a code k. The counter then advances once per 2^k source ticks. Writing the counter restarts the prescale phase.
- R5: With timer control bit 5 clear, the counter climbs by one per step from the start count. At or above the wrap value it reloads the start count, so the period is wrap − start + 1 steps.
- R6: With timer control bit 5 set, the counter climbs to the wrap value and then falls back to the start count, so the period is 2·(wrap − start) steps.
- R7: A channel runs as PWM when control bit 5 is set and bit 3 or bit 2 is set. It is active while the count is below its compare value, or, in centred mode, when the count equals the compare value on the rising half. The active width is compare − start steps when edge-aligned and 2·(compare − start) when centred. With bit 3 set the pin is high while active. With only bit 2 set the pin is inverted. Pins lag the counter by one clock.
- R8: A compare value of 0 keeps a high-true pin low for good. A compare value above the wrap value keeps it high for good.
- R9: Mask bit n forces pin n to its inactive level (low for high-true or unconfigured channels, high for low-true channels). The mask overrides every other rule.
- R10: While the counter source is 00, or while a channel is not configured as PWM, that pin shows bit n of the initial-level register.
- R11: A write of any value to the counter loads the start count and starts the next centred sweep rising. Reads of the counter return the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| fix_tick | input | 1 | One-clock pulse from the fixed count source |
| ext_tick | input | 1 | One-clock pulse from the external count source |
| pwm_out | output | 8 | Registered PWM pins, one per channel |

## Verification
A wrong counter state is visible within one clock at the counter read port, and a clock later on every configured pin. A lost or extra prescale tick therefore stretches or shortens the very next period. A wrong turn-around in centred mode shows up as an odd active width instead of the even width of 2·(compare − start). The bench reads the live count and the pins every cycle and compares them with a behavioural model, so a wrong internal state is caught within the cycle it reaches the ports. Fixed windows of whole periods then confirm the widths and periods that the formulas predict.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
    localparam int PSC_W  = 3;
    localparam int DATA_W = 32;

    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_CNT   = 8'h04;
    localparam logic [7:0] OFF_WRAP  = 8'h08;
    localparam logic [7:0] OFF_CHAN  = 8'h0C;
    localparam logic [7:0] OFF_START = 8'h4C;
    localparam logic [7:0] OFF_LEVEL = 8'h5C;
    localparam logic [7:0] OFF_MASK  = 8'h60;

    typedef enum logic [1:0] {
        SRC_OFF = 2'b00,
        SRC_SYS = 2'b01,
        SRC_FIX = 2'b10,
        SRC_EXT = 2'b11
    } clk_src_e;

    typedef struct packed {
        logic             center;
        clk_src_e         src;
        logic [PSC_W-1:0] psc;
    } tmr_ctrl_t;

    typedef struct packed {
        logic pwm_en;
        logic hi_true;
        logic lo_true;
    } ch_ctrl_t;

    function automatic ch_ctrl_t unpack_ch(input logic [DATA_W-1:0] d);
        ch_ctrl_t c;
        c.pwm_en  = d[5];
        c.hi_true = d[3];
        c.lo_true = d[2];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ch(input ch_ctrl_t c);
        logic [DATA_W-1:0] d;
        d    = '0;
        d[5] = c.pwm_en;
        d[3] = c.hi_true;
        d[2] = c.lo_true;
        return d;
    endfunction
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  clk_src_e         src,
    input  logic             fix_tick,
    input  logic             ext_tick,
    input  logic [PSC_W-1:0] psc,
    output logic             step
);
    localparam int PRE_W = (1 << PSC_W) - 1;

    logic             src_tick;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] span;

    always_comb begin
        case (src)
            SRC_SYS: src_tick = 1'b1;
            SRC_FIX: src_tick = fix_tick;
            SRC_EXT: src_tick = ext_tick;
            default: src_tick = 1'b0;
        endcase
    end

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            span[i] = (i < int'(psc));
        end
    end

    assign step = src_tick && ((pre_q & span) == span);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (src_tick) begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    assert_no_step_halted_R3: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_OFF) |-> !step);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             clr,
    input  logic             center,
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] wrap,
    output logic [CNT_W-1:0] cnt,
    output logic             rising
);
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             rise_q, rise_nxt;

    always_comb begin
        cnt_nxt  = cnt_q;
        rise_nxt = rise_q;
        if (center) begin
            if (rise_q) begin
                if (cnt_q < wrap) begin
                    cnt_nxt = cnt_q + CNT_W'(1);
                end else if (cnt_q > start) begin
                    cnt_nxt  = cnt_q - CNT_W'(1);
                    rise_nxt = 1'b0;
                end
            end else begin
                if (cnt_q > start) begin
                    cnt_nxt = cnt_q - CNT_W'(1);
                end else if (cnt_q < wrap) begin
                    cnt_nxt  = cnt_q + CNT_W'(1);
                    rise_nxt = 1'b1;
                end
            end
        end else begin
            cnt_nxt = (cnt_q >= wrap) ? start : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            rise_q <= 1'b0;
        end else if (clr) begin
            cnt_q  <= start;
            rise_q <= 1'b0;
        end else if (step) begin
            cnt_q  <= cnt_nxt;
            rise_q <= rise_nxt;
        end
    end

    assign cnt    = cnt_q;
    assign rising = rise_q;

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!step && !clr) |=> $stable(cnt_q));
    assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && !center && cnt_q >= wrap) |=> (cnt_q == $past(start)));
    assert_turn_R6: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && center && rise_q && cnt_q >= wrap && cnt_q > start)
        |=> (!rise_q && cnt_q == $past(cnt_q) - CNT_W'(1)));
    assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == $past(start) && !rise_q));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic             rising,
    input  logic             center,
    input  logic             running,
    input  ch_ctrl_t         cfg,
    input  logic [CNT_W-1:0] cmp,
    input  logic             init_lvl,
    input  logic             mask_on,
    output logic             pin
);
    logic active, configured, inactive, level, pin_nxt, pin_q;

    assign active     = (cnt < cmp) || (center && rising && cnt == cmp);
    assign configured = cfg.pwm_en && (cfg.hi_true || cfg.lo_true);
    assign inactive   = !cfg.hi_true && cfg.lo_true;
    assign level      = cfg.hi_true ? active : !active;

    always_comb begin
        if (mask_on) begin
            pin_nxt = inactive;
        end else if (!running || !configured) begin
            pin_nxt = init_lvl;
        end else begin
            pin_nxt = level;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= pin_nxt;
        end
    end

    assign pin = pin_q;

    assert_mask_high_true_R9: assert property (@(posedge clk) disable iff (rst)
        (mask_on && cfg.hi_true) |=> !pin_q);
    assert_mask_low_true_R9: assert property (@(posedge clk) disable iff (rst)
        (mask_on && !cfg.hi_true && cfg.lo_true) |=> pin_q);
    assert_zero_compare_R8: assert property (@(posedge clk) disable iff (rst)
        (running && !mask_on && cfg.pwm_en && cfg.hi_true && cmp == '0) |=> !pin_q);
    assert_stopped_level_R10: assert property (@(posedge clk) disable iff (rst)
        (!running && !mask_on) |=> (pin_q == $past(init_lvl)));
endmodule

// File: rtl/mc_pwm_timer.sv
module mc_pwm_timer
    import pwm_tmr_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fix_tick,
    input  logic              ext_tick,
    output logic [NCH-1:0]    pwm_out
);
    localparam int IDX_W    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CHAN_END = int'(OFF_CHAN) + 8 * NCH;
    localparam int CTRL_W   = $bits(tmr_ctrl_t);

    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] wrap_q, start_q;
    ch_ctrl_t         chc_q [NCH];
    logic [CNT_W-1:0] chv_q [NCH];
    logic [NCH-1:0]   level_q, mask_q;

    logic [7:0]       rel;
    logic             ch_hit, ch_is_val, cnt_wr, running, step, rising;
    logic [IDX_W-1:0] ch_idx;
    logic [CNT_W-1:0] cnt;
    logic             bus_unused;

    assign rel       = bus_addr - OFF_CHAN;
    assign ch_hit    = (int'(bus_addr) >= int'(OFF_CHAN)) && (int'(bus_addr) < CHAN_END)
                       && (rel[1:0] == 2'b00);
    assign ch_is_val = rel[2];
    assign ch_idx    = rel[3 +: IDX_W];
    assign cnt_wr    = bus_wr && (bus_addr == OFF_CNT);
    assign running   = (ctrl_q.src != SRC_OFF);
    assign bus_unused = ^{rel, bus_wdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            wrap_q  <= '0;
            start_q <= '0;
            level_q <= '0;
            mask_q  <= '0;
            for (int i = 0; i < NCH; i++) begin
                chc_q[i] <= '0;
                chv_q[i] <= '0;
            end
        end else if (bus_wr) begin
            if (ch_hit) begin
                if (ch_is_val) begin
                    chv_q[ch_idx] <= bus_wdata[CNT_W-1:0];
                end else begin
                    chc_q[ch_idx] <= unpack_ch(bus_wdata);
                end
            end else begin
                case (bus_addr)
                    OFF_CTRL:  ctrl_q  <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
                    OFF_WRAP:  wrap_q  <= bus_wdata[CNT_W-1:0];
                    OFF_START: start_q <= bus_wdata[CNT_W-1:0];
                    OFF_LEVEL: level_q <= bus_wdata[NCH-1:0];
                    OFF_MASK:  mask_q  <= bus_wdata[NCH-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (ch_hit) begin
            bus_rdata = ch_is_val ? DATA_W'(chv_q[ch_idx]) : pack_ch(chc_q[ch_idx]);
        end else begin
            case (bus_addr)
                OFF_CTRL:  bus_rdata = DATA_W'(ctrl_q);
                OFF_CNT:   bus_rdata = DATA_W'(cnt);
                OFF_WRAP:  bus_rdata = DATA_W'(wrap_q);
                OFF_START: bus_rdata = DATA_W'(start_q);
                OFF_LEVEL: bus_rdata = DATA_W'(level_q);
                OFF_MASK:  bus_rdata = DATA_W'(mask_q);
                default:   bus_rdata = '0;
            endcase
        end
    end

    pwm_tick_gen u_tick (
        .clk      (clk),
        .rst      (rst),
        .clr      (cnt_wr),
        .src      (ctrl_q.src),
        .fix_tick (fix_tick),
        .ext_tick (ext_tick),
        .psc      (ctrl_q.psc),
        .step     (step)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .clr    (cnt_wr),
        .center (ctrl_q.center),
        .start  (start_q),
        .wrap   (wrap_q),
        .cnt    (cnt),
        .rising (rising)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .cnt      (cnt),
            .rising   (rising),
            .center   (ctrl_q.center),
            .running  (running),
            .cfg      (chc_q[g]),
            .cmp      (chv_q[g]),
            .init_lvl (level_q[g]),
            .mask_on  (mask_q[g]),
            .pin      (pwm_out[g])
        );
    end

    assert_halted_count_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.src == SRC_OFF && !cnt_wr) |=> $stable(cnt));
    assert_write_restart_R11: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == $past(start_q)));
endmodule

// File: tb/sim_mc_pwm_timer.sv
module sim_mc_pwm_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h04;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fix_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic [7:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wd = 0;

    // behavioural reference state
    int m_ctrl, m_cnt, m_wrap, m_start, m_pre, m_level, m_mask;
    bit m_rise;
    int m_chc [8];
    int m_chv [8];
    logic [7:0] m_out;

    always #4 clk = ~clk;

    mc_pwm_timer u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fix_tick(fix_tick), .ext_tick(ext_tick), .pwm_out(pwm_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // expected pin from the requirement text (R7..R10)
    function automatic bit exp_pin(input int ch);
        bit en, hi, lo, act;
        en = m_chc[ch][5];
        hi = m_chc[ch][3];
        lo = m_chc[ch][2];
        if (m_mask[ch]) return (!hi && lo);
        if (((m_ctrl >> 3) & 3) == 0 || !en || !(hi || lo)) return m_level[ch];
        act = (m_cnt < m_chv[ch]) || (m_ctrl[5] && m_rise && m_cnt == m_chv[ch]);
        return hi ? act : !act;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_cnt = 0; m_wrap = 0; m_start = 0; m_pre = 0;
            m_level = 0; m_mask = 0; m_rise = 0; m_out = '0;
            for (int i = 0; i < 8; i++) begin m_chc[i] = 0; m_chv[i] = 0; end
        end else begin
            int src, k;
            bit tick, stp;
            for (int i = 0; i < 8; i++) m_out[i] = exp_pin(i);
            src = (m_ctrl >> 3) & 3;
            k = m_ctrl & 7;
            tick = (src == 1) || (src == 2 && fix_tick) || (src == 3 && ext_tick);
            stp = 0;
            if (bus_wr && bus_addr == 8'h04) begin
                m_cnt = m_start; m_rise = 0; m_pre = 0;
            end else if (tick) begin
                stp = (m_pre % (1 << k)) == ((1 << k) - 1);
                m_pre = (m_pre + 1) % 128;
            end
            if (stp) begin
                if (!m_ctrl[5]) begin
                    m_cnt = (m_cnt >= m_wrap) ? m_start : m_cnt + 1;
                end else if (m_rise) begin
                    if (m_cnt < m_wrap) m_cnt++;
                    else if (m_cnt > m_start) begin m_cnt--; m_rise = 0; end
                end else begin
                    if (m_cnt > m_start) m_cnt--;
                    else if (m_cnt < m_wrap) begin m_cnt++; m_rise = 1; end
                end
            end
            if (bus_wr) begin
                int a;
                a = int'(bus_addr);
                if (a == 'h00) m_ctrl = bus_wdata & 'h3F;
                else if (a == 'h08) m_wrap = bus_wdata & 'hFFFF;
                else if (a == 'h4C) m_start = bus_wdata & 'hFFFF;
                else if (a == 'h5C) m_level = bus_wdata & 'hFF;
                else if (a == 'h60) m_mask = bus_wdata & 'hFF;
                else if (a >= 'h0C && a < 'h4C) begin
                    if ((a - 'h0C) % 8 == 0) m_chc[(a - 'h0C) / 8] = bus_wdata & 'h2C;
                    else if ((a - 'h0C) % 8 == 4) m_chv[(a - 'h0C) / 8] = bus_wdata & 'hFFFF;
                end
            end
        end
    end

    // tick sources and per-cycle comparison with the model
    always @(negedge clk) begin
        cyc++;
        fix_tick = (cyc % 3 == 0);
        ext_tick = (cyc % 5 == 0);
        #1;
        if (!rst) begin
            chk("R7 pins vs model", int'(pwm_out), int'(m_out));
            if (bus_addr == 8'h04 && !bus_wr) chk("R11 live count vs model", int'(bus_rdata), m_cnt);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            $display("FAIL watchdog expired (R1..R11 unfinished)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h04;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        @(negedge clk);
        bus_addr = a;
        #2;
        d = int'(bus_rdata);
        #1;
        bus_addr = 8'h04;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int ch, input int n, output int highs, output int rises);
        bit prev;
        @(negedge clk); #2;
        prev = pwm_out[ch];
        highs = 0; rises = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #2;
            if (pwm_out[ch]) highs++;
            if (pwm_out[ch] && !prev) rises++;
            prev = pwm_out[ch];
        end
    endtask

    initial begin
        int d, h, r, c1, c2;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1: reset state
        rd(8'h00, d); chk("R1 control", d, 0);
        rd(8'h04, d); chk("R1 counter", d, 0);
        rd(8'h08, d); chk("R1 wrap", d, 0);
        rd(8'h0C, d); chk("R1 ch0 control", d, 0);
        rd(8'h48, d); chk("R1 ch7 compare", d, 0);
        rd(8'h60, d); chk("R1 mask", d, 0);
        chk("R1 pins", int'(pwm_out), 0);

        // R2: readback with implemented bits only
        wr(8'h08, 32'hABCD1234); rd(8'h08, d); chk("R2 wrap readback", d, 'h1234);
        wr(8'h38, 32'h0000BEEF); rd(8'h38, d); chk("R2 ch5 compare readback", d, 'hBEEF);
        wr(8'h1C, 32'hFFFFFFFF); rd(8'h1C, d); chk("R2 ch2 control readback", d, 'h2C);
        wr(8'h5C, 32'h000000A5); rd(8'h5C, d); chk("R2 level readback", d, 'hA5);
        wr(8'h60, 32'h000001FF); rd(8'h60, d); chk("R2 mask readback", d, 'hFF);
        wr(8'h00, 32'hFFFFFFEA); rd(8'h00, d); chk("R2 control readback", d, 'h2A);
        wr(8'h00, 0); wr(8'h60, 0);

        // R5/R7/R8/R10: edge aligned, start 2, wrap 11, period 10
        wr(8'h4C, 2); wr(8'h08, 11);
        wr(8'h0C, 'h28); wr(8'h10, 5);
        wr(8'h14, 'h24); wr(8'h18, 5);
        wr(8'h1C, 'h28); wr(8'h20, 0);
        wr(8'h24, 'h28); wr(8'h28, 20);
        wr(8'h2C, 0);    wr(8'h5C, 'h10);
        wr(8'h00, 'h08); wr(8'h04, 'hFFFF);
        idle(5);
        measure(0, 40, h, r); chk("R5 ch0 active width", h, 12); chk("R5 ch0 period", r, 4);
        measure(1, 40, h, r); chk("R7 ch1 low-true width", h, 28);
        measure(2, 40, h, r); chk("R8 zero compare inactive", h, 0);
        measure(3, 40, h, r); chk("R8 compare above wrap active", h, 40);
        measure(4, 40, h, r); chk("R10 unconfigured shows level", h, 40);

        // R6: centred, start 0, wrap 8, period 16, width 6
        wr(8'h4C, 0); wr(8'h08, 8); wr(8'h10, 3);
        wr(8'h00, 'h28); wr(8'h04, 0);
        idle(3);
        measure(0, 48, h, r); chk("R6 centred width", h, 18); chk("R6 centred period", r, 3);

        // R4: prescale code 2, edge, period 40 clocks
        wr(8'h4C, 2); wr(8'h08, 11); wr(8'h10, 5);
        wr(8'h00, 'h0A); wr(8'h04, 0);
        idle(4);
        measure(0, 80, h, r); chk("R4 prescaled width", h, 24); chk("R4 prescaled period", r, 2);

        // R3: fixed ticks every 3 clocks, external every 5 clocks
        wr(8'h00, 'h10); idle(4);
        measure(0, 60, h, r); chk("R3 fixed source width", h, 18);
        wr(8'h00, 'h18); idle(4);
        measure(0, 100, h, r); chk("R3 external source width", h, 30);

        // R3/R10: halted source
        wr(8'h00, 0); idle(2);
        rd(8'h04, c1); idle(10); rd(8'h04, c2);
        chk("R3 halted count stable", c2, c1);
        chk("R10 halted pins show levels", int'(pwm_out), 'h10);

        // R9: mask forces inactive levels
        wr(8'h00, 'h08); wr(8'h60, 'h13); idle(2);
        measure(0, 20, h, r); chk("R9 masked high-true low", h, 0);
        measure(1, 20, h, r); chk("R9 masked low-true high", h, 20);
        measure(4, 20, h, r); chk("R9 masked unconfigured low", h, 0);
        wr(8'h60, 0);

        // R11: counter write loads start count
        wr(8'h00, 0); wr(8'h08, 'h4000); wr(8'h4C, 'h100);
        wr(8'h04, 'hFFFF); rd(8'h04, d); chk("R11 write loads start", d, 'h100);
        wr(8'h00, 'h08); idle(20);
        wr(8'h04, 'h1234); rd(8'h04, d); chk("R11 running write reloads", d, 'h101);

        idle(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule